// File: doc/BRIEF.md
# Dual-Channel Control Handover Arbiter

This block chooses which of two redundant controller channels, called primary and secondary, may drive the shared outputs. It produces one output-enable per channel and a four-bit status word. Each channel supplies an unsigned health score, a consent flag and an accept flag as parallel inputs. When the active channel scores strictly lower than the standby and has given consent, the arbiter drops the active enable and waits for the standby to accept. If the standby does not accept within a programmable number of cycles, control returns to the original channel and a takeback flag is raised.

After reset the block runs a start-up sequence. The secondary channel holds control until a speed input rises strictly above a threshold input. Control is then forced over to the primary. This makes every start exercise the secondary channel and the handover path, so faults in either cannot stay hidden. A manual override input pins the selection to a chosen channel while it is held. Every change of owner leaves at least one cycle with both enables low. A separate interlock stage, downstream of the decision logic, makes sure the two enables are never high together.

Top module: `dual_chan_handover`

## Requirements
- R1: `en_p` and `en_s` are never both 1 in the same cycle, and this is enforced by an interlock stage separate from the selection logic.
- R2: An enable goes from 0 to 1 only when both enables were 0 in the previous cycle.
- R3: After reset the secondary is enabled and status bit 3 is 1. When `speed > speed_thresh` (unsigned, strict), the next cycle has both enables at 0 and the cycle after that has the primary enabled. While `speed <= speed_thresh` the secondary stays enabled.
- R4: While `man_en` is 1, automatic selection and the start-up sequence are suspended and `man_sel` decides the channel (0 = primary, 1 = secondary). A change of channel from a running state passes through one cycle with both enables at 0. Status bit 2 follows `man_en` in the same cycle.
- R5: Outside start-up and without override, the active channel gives up control only when its health is strictly below the standby's health and its own yield input is 1. Both enables are then 0 from the next cycle on.
- R6: Equal health, higher active health, or a 0 on the active channel's yield input causes no change of control.
- R7: While both enables are low after a relinquish, a 1 on the standby's accept input hands control to the standby, whose enable is 1 from the next cycle on.
- R8: If no accept arrives within `takeback_lim` cycles of the relinquish (a value of 0 acts as 1), the original channel is enabled again and status bit 1 becomes 1. That bit stays 1 until the next relinquish starts or until reset.
- R9: Status bit 0 gives the channel that owns control (0 = primary, 1 = secondary). During a handover it shows the previous owner.
- R10: Asynchronous reset with `rst_n` low gives `en_p`=0, `en_s`=1 and status bits 3, 1 and 0 as 1, 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| health_p | input | HW | Primary channel health score |
| health_s | input | HW | Secondary channel health score |
| yield_p | input | 1 | Primary gives consent to hand over |
| yield_s | input | 1 | Secondary gives consent to hand over |
| accept_p | input | 1 | Primary ready to take control |
| accept_s | input | 1 | Secondary ready to take control |
| speed | input | SW | Shaft speed |
| speed_thresh | input | SW | Start-up transfer threshold |
| takeback_lim | input | CW | Accept timeout in cycles |
| man_en | input | 1 | Manual override active |
| man_sel | input | 1 | Manual channel choice |
| en_p | output | 1 | Primary output-enable |
| en_s | output | 1 | Secondary output-enable |
| status | output | 4 | {in_start, manual, takeback, active} |

## Verification
The bench goes after the boundaries that a faulty design would get wrong. A speed exactly at the threshold must not transfer, and a design using `>=` would hand over one step early. Equal health must not trigger a switch, and a `<=` comparison would make the channels oscillate. The accept timeout must expire after exactly the set count, including a limit of one, so an off-by-one counter would show up as a takeback one cycle early or late. The bench also issues a manual selection during a pending handover and during start-up, which a design that lets the automatic path win would mishandle, and it checks that the dead cycle is present at every change of owner.

// File: rtl/dch_pkg.sv
package dch_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_RUN   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_BRK   = 2'd3
  } dch_state_e;

  typedef struct packed {
    logic in_start;
    logic manual;
    logic takeback;
    logic active;
  } dch_status_t;
endpackage

// File: rtl/dch_timer.sv
module dch_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign expire = !clr && (cnt_nx >= {1'b0, lim});

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (!expire) cnt_d = cnt_nx[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dch_decide.sv
module dch_decide
  import dch_pkg::*;
#(
  parameter int HW = 8,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] health_p,
  input  logic [HW-1:0] health_s,
  input  logic          yield_p,
  input  logic          yield_s,
  input  logic          accept_p,
  input  logic          accept_s,
  input  logic [SW-1:0] speed,
  input  logic [SW-1:0] speed_thresh,
  input  logic          man_en,
  input  logic          man_sel,
  input  logic          expire,
  output logic          tmr_clr,
  output logic          raw_p,
  output logic          raw_s,
  output dch_status_t   status
);
  dch_state_e st_q, st_d;
  logic       act_q, act_d;
  logic       tgt_q, tgt_d;
  logic       tb_q, tb_d;
  logic [HW-1:0] hl_act, hl_sby;
  logic       yld_act, acc_sby;

  assign hl_act  = act_q ? health_s : health_p;
  assign hl_sby  = act_q ? health_p : health_s;
  assign yld_act = act_q ? yield_s  : yield_p;
  assign acc_sby = act_q ? accept_p : accept_s;

  always_comb begin
    st_d  = st_q;
    act_d = act_q;
    tgt_d = tgt_q;
    tb_d  = tb_q;
    unique case (st_q)
      ST_START: begin
        if (man_en) begin
          if (man_sel) begin
            st_d  = ST_RUN;
            act_d = 1'b1;
          end else begin
            st_d  = ST_BRK;
            tgt_d = 1'b0;
          end
        end else if (speed > speed_thresh) begin
          st_d  = ST_BRK;
          tgt_d = 1'b0;
        end
      end
      ST_RUN: begin
        if (man_en) begin
          if (man_sel != act_q) begin
            st_d  = ST_BRK;
            tgt_d = man_sel;
          end
        end else if ((hl_act < hl_sby) && yld_act) begin
          st_d = ST_WAIT;
          tb_d = 1'b0;
        end
      end
      ST_WAIT: begin
        if (man_en) begin
          st_d  = ST_RUN;
          act_d = man_sel;
        end else if (acc_sby) begin
          st_d  = ST_RUN;
          act_d = ~act_q;
        end else if (expire) begin
          st_d = ST_RUN;
          tb_d = 1'b1;
        end
      end
      default: begin
        st_d  = ST_RUN;
        act_d = tgt_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_START;
      act_q <= 1'b1;
      tgt_q <= 1'b1;
      tb_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
      tgt_q <= tgt_d;
      tb_q  <= tb_d;
    end
  end

  assign tmr_clr = (st_q != ST_WAIT);
  assign raw_p   = (st_q == ST_RUN) && !act_q;
  assign raw_s   = ((st_q == ST_RUN) && act_q) || (st_q == ST_START);

  always_comb begin
    status.in_start = (st_q == ST_START);
    status.manual   = man_en;
    status.takeback = tb_q;
    status.active   = act_q;
  end

  // R3
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && !man_en && speed <= speed_thresh) |=> (st_q == ST_START));
  // R4
  manual_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && man_en && man_sel == act_q) |=> (st_q == ST_RUN && act_q == $past(act_q)));
  // R6
  no_consent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !man_en && (!yld_act || hl_act >= hl_sby)) |=> (st_q == ST_RUN && act_q == $past(act_q)));
  // R8
  takeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !man_en && !acc_sby && expire) |=> (st_q == ST_RUN && act_q == $past(act_q) && tb_q));
endmodule

// File: rtl/dch_interlock.sv
module dch_interlock (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_p,
  input  logic raw_s,
  output logic en_p,
  output logic en_s
);
  logic prev_p_q, prev_s_q;

  assign en_p = raw_p && !raw_s && !prev_s_q;
  assign en_s = raw_s && !raw_p && !prev_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_p_q <= 1'b0;
      prev_s_q <= 1'b0;
    end else begin
      prev_p_q <= en_p;
      prev_s_q <= en_s;
    end
  end

  // R1
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(en_p && en_s));
  // R2
  bbm_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_p) |-> $past(!en_s && !en_p));
  // R2
  bbm_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_s) |-> $past(!en_s && !en_p));
endmodule

// File: rtl/dual_chan_handover.sv
module dual_chan_handover
  import dch_pkg::*;
#(
  parameter int HW = 8,
  parameter int SW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] health_p,
  input  logic [HW-1:0] health_s,
  input  logic          yield_p,
  input  logic          yield_s,
  input  logic          accept_p,
  input  logic          accept_s,
  input  logic [SW-1:0] speed,
  input  logic [SW-1:0] speed_thresh,
  input  logic [CW-1:0] takeback_lim,
  input  logic          man_en,
  input  logic          man_sel,
  output logic          en_p,
  output logic          en_s,
  output logic [3:0]    status
);
  logic        tmr_clr, expire, raw_p, raw_s;
  dch_status_t st_w;

  dch_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .lim(takeback_lim), .expire(expire)
  );

  dch_decide #(.HW(HW), .SW(SW)) u_decide (
    .clk(clk), .rst_n(rst_n),
    .health_p(health_p), .health_s(health_s),
    .yield_p(yield_p), .yield_s(yield_s),
    .accept_p(accept_p), .accept_s(accept_s),
    .speed(speed), .speed_thresh(speed_thresh),
    .man_en(man_en), .man_sel(man_sel),
    .expire(expire), .tmr_clr(tmr_clr),
    .raw_p(raw_p), .raw_s(raw_s), .status(st_w)
  );

  dch_interlock u_lock (
    .clk(clk), .rst_n(rst_n), .raw_p(raw_p), .raw_s(raw_s), .en_p(en_p), .en_s(en_s)
  );

  assign status = st_w;

  // R9
  owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_p |-> !status[0]) and (en_s |-> status[0]));
endmodule

// File: tb/sim_dual_chan_handover.sv
module sim_dual_chan_handover;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  health_p = 8'd50, health_s = 8'd50;
  logic        yield_p = 0, yield_s = 0, accept_p = 0, accept_s = 0;
  logic [15:0] speed = 0, speed_thresh = 16'd1000;
  logic [7:0]  takeback_lim = 8'd4;
  logic        man_en = 0, man_sel = 0;
  logic        en_p, en_s;
  logic [3:0]  status;

  int total = 0, bad = 0, cyc = 0;
  string tag = "R10";
  bit done = 0;

  always #5 clk = ~clk;

  dual_chan_handover u0 (.*);

  // behavioural reference: mode 0 start, 1 run, 2 wait, 3 break
  int m_mode, m_act, m_tgt, m_cnt, m_tb;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_act = 1; m_tgt = 1; m_cnt = 0; m_tb = 0;
    end else begin
      int ha, hs, y, a, lim;
      ha = m_act ? health_s : health_p;
      hs = m_act ? health_p : health_s;
      y  = m_act ? yield_s : yield_p;
      a  = m_act ? accept_p : accept_s;
      lim = (takeback_lim == 0) ? 1 : takeback_lim;
      if (m_mode == 0) begin
        if (man_en) begin
          if (man_sel) m_mode = 1; else begin m_mode = 3; m_tgt = 0; end
        end else if (speed > speed_thresh) begin m_mode = 3; m_tgt = 0; end
      end else if (m_mode == 1) begin
        if (man_en) begin
          if (man_sel != m_act) begin m_mode = 3; m_tgt = man_sel; end
        end else if (ha < hs && y) begin m_mode = 2; m_cnt = 0; m_tb = 0; end
      end else if (m_mode == 2) begin
        m_cnt++;
        if (man_en) begin m_mode = 1; m_act = man_sel; end
        else if (a) begin m_mode = 1; m_act = 1 - m_act; end
        else if (m_cnt >= lim) begin m_mode = 1; m_tb = 1; end
      end else begin
        m_mode = 1; m_act = m_tgt;
      end
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", t, cyc, act, exp);
    end
  endtask

  logic pp = 0, ps = 0;
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      chk({tag, " en_p"}, en_p, (m_mode == 1 && m_act == 0));
      chk({tag, " en_s"}, en_s, ((m_mode == 1 && m_act == 1) || m_mode == 0));
      chk({tag, " status"}, status, {m_mode == 0, man_en, m_tb[0], m_act[0]});
      chk("R9 owner", status[0], m_act);
      chk("R1 exclusive", en_p & en_s, 0);
      if ((en_p && !pp) || (en_s && !ps)) chk("R2 dead cycle", pp | ps, 0);
      pp = en_p; ps = en_s;
    end
  endtask

  initial begin
    #1;
    tag = "R10";
    @(negedge clk);
    chk("R10 reset en_s", en_s, 1);
    chk("R10 reset en_p", en_p, 0);
    chk("R10 reset status", status, 4'b1001);
    rst_n = 1;
    step(2);
    tag = "R3"; speed = 16'd1000; step(3);
    chk("R3 at threshold holds secondary", en_s, 1);
    speed = 16'd1001; step(1);
    chk("R3 dead cycle", en_p | en_s, 0);
    step(1);
    chk("R3 primary after start", en_p, 1);
    step(2);
    tag = "R6"; yield_p = 1; step(3);
    health_p = 60; step(3);
    chk("R6 healthier active kept", en_p, 1);
    tag = "R5"; health_p = 40; yield_p = 0; step(3);
    chk("R5 no consent kept", en_p, 1);
    yield_p = 1; step(1); yield_p = 0;
    chk("R5 relinquish drops enable", en_p, 0);
    tag = "R8"; step(6);
    chk("R8 takeback flag", status[1], 1);
    chk("R8 original back", en_p, 1);
    tag = "R7"; yield_p = 1; step(1); yield_p = 0; step(1);
    accept_s = 1; step(1); accept_s = 0; step(2);
    chk("R7 standby took over", en_s, 1);
    chk("R8 flag cleared by relinquish", status[1], 0);
    health_s = 20; yield_s = 1; accept_p = 1; step(3);
    yield_s = 0; accept_p = 0; step(2);
    chk("R7 back to primary", en_p, 1);
    tag = "R4"; health_s = 80; yield_p = 1; man_en = 1; man_sel = 0; step(3);
    chk("R4 manual holds primary", en_p, 1);
    man_sel = 1; step(3);
    chk("R4 manual secondary", en_s, 1);
    man_en = 0; yield_p = 0; health_s = 30; health_p = 50; step(1);
    yield_s = 1; step(1); yield_s = 0;
    man_en = 1; man_sel = 1; step(1); man_en = 0; step(2);
    chk("R4 manual cancels wait", en_s, 1);
    tag = "R8"; takeback_lim = 1; yield_s = 1; step(1); yield_s = 0; step(4);
    chk("R8 limit one", status[1], 1);
    takeback_lim = 0; yield_s = 1; step(1); yield_s = 0; step(4);
    chk("R8 limit zero as one", en_s, 1);
    tag = "R4"; rst_n = 0; speed = 0; #1; step(1); rst_n = 1;
    man_en = 1; man_sel = 0; step(3);
    chk("R4 manual during start", en_p, 1);
    man_en = 0; step(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule